// File: doc/BRIEF.md
# Two-Wire Character LCD Nibble Serializer

This block drives a character LCD that sits behind an external 8-bit serial-in, parallel-out shift register. Only two wires run to that register: a serial data line and a serial clock. A host hands the block one request at a time on a valid/ready port. Each request carries a register-select bit and a 4-bit nibble. The block turns the request into a framed bit train on the two wires. The frame is a run of zero bits, then a one used as a marker, then the select bit, then the nibble from its most significant bit down, then a closing zero clock. This leaves the marker on the last register stage and the other fields on the stages below it.

The LCD enable has no wire of its own. Off-chip logic ANDs the last register stage with the serial data line. Once the frame is in place, the block raises the data line with the clock held still, and that level is the enable strobe. The strobe length comes from a 450 ns minimum and the system clock frequency, rounded up. After the strobe, the block stays busy for a set wait that covers the LCD's execution time. The very first frame after reset carries one more leading zero than later frames, so that whatever the register held at power-up is flushed out.

Top module: `lcd2w_serializer`

## Requirements
- R1: While reset is held, and in every idle cycle, `ser_clk` and `ser_dat` are both 0. After reset, `req_ready` is 1 and `busy` is 0.
- R2: The first frame after reset starts with LEAD_FIRST (7) zero bits before the marker. The frame has LEAD_FIRST+7 rising clock edges in all.
- R3: Every later frame starts with LEAD_NEXT (6) zero bits before the marker. The frame has LEAD_NEXT+7 rising clock edges.
- R4: `ser_dat` changes only in a cycle where `ser_clk` is 0 and was also 0 in the cycle before. It never changes in the cycle where `ser_clk` rises.
- R5: After the zeros, the bits go out in this order: a 1 marker, RS, then `req_nib[3]` down to `req_nib[0]`, then one more clock with the data line at 0. Stage index 0 is the stage fed by the data line. When the strobe starts, stage 6 holds the marker, stage 5 holds RS, and stages 4 to 1 hold `req_nib[3:0]`.
- R6: After the closing clock, `ser_dat` stays at 1 for exactly STROBE_CYC cycles, with no clock edge, and then returns to 0. STROBE_CYC = ceil(STROBE_NS × CLK_HZ / 1e9), which is 23 cycles at 50 MHz and 450 ns.
- R7: Each high phase of `ser_clk` lasts SCK_HALF system cycles. Consecutive rising edges within a frame are 2×SCK_HALF cycles apart.
- R8: From the cycle after acceptance, `req_ready` is 0 and `busy` is 1 for exactly B×2×SCK_HALF + STROBE_CYC + POST_WAIT + 2 cycles, where B is the frame bit count. Then both return to idle.
- R9: The modelled enable (stage 6 AND `ser_dat`) rises exactly once per completed request, and never during a frame that reset cuts short.
- R10: RS and the nibble are captured in the acceptance cycle. Changes on the request inputs while busy have no effect on the frame being sent.
- R11: A reset during a frame drives both lines low and returns to idle. The next frame again uses LEAD_FIRST leading zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can take a request this cycle |
| req_rs | input | 1 | Register-select bit for the LCD |
| req_nib | input | 4 | Nibble to write, bit 3 is sent first |
| ser_clk | output | 1 | Serial clock to the shift register |
| ser_dat | output | 1 | Serial data line, which also forms the strobe |
| busy | output | 1 | A frame, strobe or post-write wait is in progress |

## Verification
The properties assume the external register shifts only on rising edges of `ser_clk`. They also assume the host never depends on a request being taken while `req_ready` is low. Under those assumptions, every data-line transition is judged against the clock phase alone. The stimulus offers requests only from an idle state. It then keeps `req_valid` high for several busy cycles with the RS and nibble values inverted, so the inputs are exercised without ever making a second acceptance legal. Random RS and nibble values, mixed with all-zero, all-one and alternating patterns, drive the frame. One reset in mid-frame tests the abort path and the return of the longer leading run.

// File: rtl/lcd2w_pkg.sv
// Shared types and constant helpers for the two-wire LCD serializer.
// Assumes the frame body is the marker, RS, four data bits and one closing zero.
package lcd2w_pkg;

    // Sequencer phases: idle, clock low, clock high, enable strobe, post-write wait.
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_LOW,
        SEQ_HIGH,
        SEQ_STROBE,
        SEQ_WAIT
    } seq_state_e;

    // Bits in a frame after the leading zeros: marker, RS, 4 data bits, closing zero.
    localparam int unsigned BODY_BITS = 7;

    // Converts a time in ns to system cycles, rounding up; never returns 0.
    function automatic int unsigned ns_to_cycles(input longint unsigned clk_hz,
                                                 input longint unsigned ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = clk_hz * ns;
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc == 64'd0) cyc = 64'd1;
        return 32'(cyc);
    endfunction

    // Largest of three counts, used to size a shared phase counter.
    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/lcd2w_frame.sv
// Frame image holder: on load it builds the zero run plus the body, MSB first.
// On each shift it moves to the next bit and counts down the bits left.
// It also holds the first-write flag, which picks the longer leading run once after reset.
// Assumes LEAD_NEXT <= LEAD_FIRST and LEAD_NEXT >= 1.
module lcd2w_frame
    import lcd2w_pkg::*;
#(
    parameter int unsigned LEAD_FIRST = 7,
    parameter int unsigned LEAD_NEXT  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       shift_i,
    input  logic       rs_i,
    input  logic [3:0] nib_i,
    output logic       bit_o,
    output logic       last_o
);

    localparam int unsigned FRAME_W = LEAD_FIRST + BODY_BITS;
    localparam int unsigned SKEW    = LEAD_FIRST - LEAD_NEXT;
    localparam int unsigned LEFT_W  = $clog2(FRAME_W + 1);

    logic [BODY_BITS-1:0] body;
    logic [FRAME_W-1:0]   first_img;
    logic [FRAME_W-1:0]   next_img;
    logic [FRAME_W-1:0]   frame_q;
    logic [LEFT_W-1:0]    left_q;
    logic                 first_q;

    // Body layout, first bit sent on the left: marker, RS, D7..D4, closing zero.
    assign body      = {1'b1, rs_i, nib_i, 1'b0};
    assign first_img = {{LEAD_FIRST{1'b0}}, body};

    // Image for later writes: a shorter zero run, with the body aligned to the top.
    generate
        if (SKEW == 0) begin : g_same_lead
            assign next_img = first_img;
        end else begin : g_short_lead
            assign next_img = {{LEAD_NEXT{1'b0}}, body, {SKEW{1'b0}}};
        end
    endgenerate

    // Loads a new image on acceptance, or advances one bit per serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            frame_q <= '0;
            left_q  <= '0;
        end else if (load_i) begin
            frame_q <= first_q ? first_img : next_img;
            left_q  <= first_q ? LEFT_W'(FRAME_W) : LEFT_W'(FRAME_W - SKEW);
            first_q <= 1'b0;
        end else if (shift_i) begin
            frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
            left_q  <= left_q - LEFT_W'(1);
        end
    end

    assign bit_o  = frame_q[FRAME_W-1];
    assign last_o = (left_q == LEFT_W'(1));

endmodule

// File: rtl/lcd2w_seq.sv
// Wire sequencer. It paces the serial clock in system-clock half periods.
// It places each data bit one cycle after the clock falls, then raises the strobe,
// then waits out the LCD execution time.
// Assumes SCK_HALF >= 2 and STROBE_CYC >= 1.
module lcd2w_seq
    import lcd2w_pkg::*;
#(
    parameter int unsigned SCK_HALF   = 2,
    parameter int unsigned STROBE_CYC = 23,
    parameter int unsigned POST_WAIT  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic cur_bit_i,
    input  logic last_bit_i,
    output logic ready_o,
    output logic busy_o,
    output logic load_o,
    output logic shift_o,
    output logic sck_o,
    output logic sda_o
);

    localparam int unsigned CNT_MAX = max3(SCK_HALF, STROBE_CYC, POST_WAIT);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] HALF_END   = CNT_W'(SCK_HALF - 1);
    localparam logic [CNT_W-1:0] STROBE_END = CNT_W'(STROBE_CYC);
    localparam logic [CNT_W-1:0] WAIT_END   = CNT_W'(POST_WAIT);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sck_q;
    logic             sda_q;

    // Handshake and frame-control strobes decoded from the current phase.
    always_comb begin
        ready_o = (state_q == SEQ_IDLE);
        busy_o  = (state_q != SEQ_IDLE);
        load_o  = (state_q == SEQ_IDLE) && valid_i;
        shift_o = (state_q == SEQ_HIGH) && (cnt_q == HALF_END);
    end

    // Phase machine with a shared counter; drives both wire registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            sck_q   <= 1'b0;
            sda_q   <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    cnt_q <= '0;
                    if (valid_i) state_q <= SEQ_LOW;
                end
                SEQ_LOW: begin
                    if (cnt_q == '0) sda_q <= cur_bit_i;
                    if (cnt_q == HALF_END) begin
                        sck_q   <= 1'b1;
                        cnt_q   <= '0;
                        state_q <= SEQ_HIGH;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                SEQ_HIGH: begin
                    if (cnt_q == HALF_END) begin
                        sck_q   <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= last_bit_i ? SEQ_STROBE : SEQ_LOW;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                SEQ_STROBE: begin
                    if (cnt_q == '0) sda_q <= 1'b1;
                    if (cnt_q == STROBE_END) begin
                        sda_q   <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= SEQ_WAIT;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                SEQ_WAIT: begin
                    if (cnt_q == WAIT_END) begin
                        cnt_q   <= '0;
                        state_q <= SEQ_IDLE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    cnt_q   <= '0;
                    sck_q   <= 1'b0;
                    sda_q   <= 1'b0;
                end
            endcase
        end
    end

    assign sck_o = sck_q;
    assign sda_o = sda_q;

endmodule

// File: rtl/lcd2w_serializer.sv
// Top of the two-wire LCD nibble serializer.
// It takes RS and a nibble on a valid/ready port, frames them for an external 8-bit shift register,
// and forms the LCD enable by holding the data line high with the clock idle.
// Assumes the shift register samples data on the rising edge of ser_clk.
module lcd2w_serializer
    import lcd2w_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned SCK_HALF   = 2,
    parameter int unsigned STROBE_NS  = 450,
    parameter int unsigned POST_WAIT  = 16,
    parameter int unsigned LEAD_FIRST = 7,
    parameter int unsigned LEAD_NEXT  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_rs,
    input  logic [3:0] req_nib,
    output logic       ser_clk,
    output logic       ser_dat,
    output logic       busy
);

    localparam int unsigned STROBE_CYC = ns_to_cycles(64'(CLK_HZ), 64'(STROBE_NS));

    logic load;
    logic shift;
    logic cur_bit;
    logic last_bit;

    // Holds the frame image and the first-write selection.
    lcd2w_frame #(
        .LEAD_FIRST (LEAD_FIRST),
        .LEAD_NEXT  (LEAD_NEXT)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .rs_i    (req_rs),
        .nib_i   (req_nib),
        .bit_o   (cur_bit),
        .last_o  (last_bit)
    );

    // Paces the serial clock, the strobe and the post-write wait.
    lcd2w_seq #(
        .SCK_HALF   (SCK_HALF),
        .STROBE_CYC (STROBE_CYC),
        .POST_WAIT  (POST_WAIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (req_valid),
        .cur_bit_i  (cur_bit),
        .last_bit_i (last_bit),
        .ready_o    (req_ready),
        .busy_o     (busy),
        .load_o     (load),
        .shift_o    (shift),
        .sck_o      (ser_clk),
        .sda_o      (ser_dat)
    );

endmodule

// File: rtl/lcd2w_checker.sv
// Protocol checker for the serializer's wires and handshake. It is bound onto the top.
// Assumes synchronous active-low reset; the counters cover windows that depend on parameters.
module lcd2w_checker #(
    parameter int unsigned SCK_HALF   = 2,
    parameter int unsigned STROBE_CYC = 23
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic ser_clk,
    input logic ser_dat,
    input logic busy
);

    logic [15:0] sck_run;
    logic [15:0] dat_run;
    logic        dat_quiet;

    // Counts consecutive cycles with the serial clock high.
    always_ff @(posedge clk) begin
        if (!rst_n)       sck_run <= '0;
        else if (ser_clk) sck_run <= (sck_run == 16'hFFFF) ? sck_run : sck_run + 16'd1;
        else              sck_run <= '0;
    end

    // Counts the data-high run, and notes whether the clock stayed low for all of it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_run   <= '0;
            dat_quiet <= 1'b0;
        end else if (ser_dat) begin
            dat_run   <= (dat_run == 16'hFFFF) ? dat_run : dat_run + 16'd1;
            dat_quiet <= ((dat_run == 16'd0) ? 1'b1 : dat_quiet) && !ser_clk;
        end else begin
            dat_run   <= '0;
            dat_quiet <= 1'b0;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_clk && !ser_dat));

    p_hold_at_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_dat));

    p_change_when_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_dat) |-> (!ser_clk && !$past(ser_clk)));

    p_strobe_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ser_dat) && dat_quiet) |-> (dat_run >= 16'(STROBE_CYC)));

    p_half_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> (sck_run == 16'(SCK_HALF)));

    p_clock_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> busy);

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready));

endmodule

bind lcd2w_serializer lcd2w_checker #(
    .SCK_HALF   (SCK_HALF),
    .STROBE_CYC (STROBE_CYC)
) u_lcd2w_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ser_clk   (ser_clk),
    .ser_dat   (ser_dat),
    .busy      (busy)
);

// File: tb/lcd2w_serializer_bench.sv
// Self-checking bench. It models the external shift register and the enable AND gate,
// then checks each write's framing, timing and strobe against values computed here.
module lcd2w_serializer_bench;

    localparam int CLK_HZ     = 50_000_000;
    localparam int SCK_HALF   = 2;
    localparam int STROBE_NS  = 450;
    localparam int POST_WAIT  = 16;
    localparam int LEAD_FIRST = 7;
    localparam int LEAD_NEXT  = 6;
    localparam int EXP_STROBE = ((CLK_HZ / 1_000_000) * STROBE_NS + 999) / 1000;

    logic       clk;
    logic       rst_n;
    logic       req_valid;
    logic       req_ready;
    logic       req_rs;
    logic [3:0] req_nib;
    logic       ser_clk;
    logic       ser_dat;
    logic       busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit exp_first;
    bit after_abort;
    bit timed_out;

    initial clk = 1'b0;
    always #10 clk = ~clk;

    lcd2w_serializer #(
        .CLK_HZ     (CLK_HZ),
        .SCK_HALF   (SCK_HALF),
        .STROBE_NS  (STROBE_NS),
        .POST_WAIT  (POST_WAIT),
        .LEAD_FIRST (LEAD_FIRST),
        .LEAD_NEXT  (LEAD_NEXT)
    ) u_lcd2w_serializer (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_rs    (req_rs),
        .req_nib   (req_nib),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .busy      (busy)
    );

    // External 8-bit shift register model, stage 0 fed by the data line; powers up all ones.
    logic [7:0] sr_q = 8'hFF;
    always @(posedge ser_clk) sr_q <= {sr_q[6:0], ser_dat};
    wire lcd_en = sr_q[6] & ser_dat;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int frame_bits(input bit first);
        return (first ? LEAD_FIRST : LEAD_NEXT) + 7;
    endfunction

    function automatic int busy_len(input bit first);
        return frame_bits(first) * 2 * SCK_HALF + EXP_STROBE + POST_WAIT + 2;
    endfunction

    // Offers one request and watches the wires until ready returns, then checks the write.
    task automatic do_write(input bit rs, input logic [3:0] nib);
        int lead = 0, rises = 0, en_rises = 0, en_hi = 0, cyc = 0, last_rise = 0, hr = 0;
        bit seen = 0, bad4 = 0, bad7 = 0, bad8 = 0, cap_rs = 0;
        bit prev_sck = 0, prev_sda = 0, prev_en = 0;
        logic [3:0] cap_nib = 4'h0;
        string lt;
        lt = after_abort ? "R11" : (exp_first ? "R2" : "R3");
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_rs    = rs;
        req_nib   = nib;
        @(negedge clk);
        while (!req_ready && !timed_out) begin
            cyc++;
            if (cyc <= 8) begin
                req_rs  = ~rs;
                req_nib = ~nib;
            end else begin
                req_valid = 1'b0;
            end
            if (!busy) bad8 = 1;
            if ((ser_dat != prev_sda) && (ser_clk || prev_sck)) bad4 = 1;
            if (ser_clk && !prev_sck) begin
                if (rises > 0 && (cyc - last_rise) != 2 * SCK_HALF) bad7 = 1;
                last_rise = cyc;
                rises++;
                if (!seen) begin
                    if (ser_dat) seen = 1;
                    else         lead++;
                end
            end
            if (ser_clk) hr++;
            else if (prev_sck) begin
                if (hr != SCK_HALF) bad7 = 1;
                hr = 0;
            end
            if (lcd_en && !prev_en) begin
                en_rises++;
                cap_rs  = sr_q[5];
                cap_nib = sr_q[4:1];
            end
            if (lcd_en && en_rises == 1) en_hi++;
            prev_sck = ser_clk;
            prev_sda = ser_dat;
            prev_en  = lcd_en;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(lead == (exp_first ? LEAD_FIRST : LEAD_NEXT), lt, "leading zeros", lead,
            exp_first ? LEAD_FIRST : LEAD_NEXT);
        chk(rises == frame_bits(exp_first), lt, "clock edges", rises, frame_bits(exp_first));
        chk(!bad4, "R4", "data changed near a clock edge", int'(bad4), 0);
        chk(cap_nib == nib, "R5,R10", "nibble at strobe", int'(cap_nib), int'(nib));
        chk(cap_rs == rs, "R5,R10", "RS at strobe", int'(cap_rs), int'(rs));
        chk(en_hi == EXP_STROBE, "R6", "strobe cycles", en_hi, EXP_STROBE);
        chk(!bad7, "R7", "clock phase timing", int'(bad7), 0);
        chk(cyc == busy_len(exp_first) && !bad8, "R8", "busy cycles", cyc, busy_len(exp_first));
        chk(!busy && !ser_clk && !ser_dat, "R8", "idle after write", int'(busy), 0);
        chk(en_rises == 1, "R9", "enable pulses", en_rises, 1);
        exp_first   = 1'b0;
        after_abort = 1'b0;
    endtask

    // Starts a write, resets in the middle of it, and checks the idle state and that no strobe occurred.
    task automatic abort_write();
        int en_rises = 0;
        bit prev_en = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_rs    = 1'b1;
        req_nib   = 4'hF;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 24; i++) begin
            if (i == 20) rst_n = 1'b0;
            if (lcd_en && !prev_en) en_rises++;
            prev_en = lcd_en;
            @(negedge clk);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ser_clk && !ser_dat, "R11", "lines after abort", int'({ser_clk, ser_dat}), 0);
        chk(req_ready && !busy, "R11", "ready after abort", int'(req_ready), 1);
        chk(en_rises == 0, "R9", "enable pulses in aborted write", en_rises, 0);
        exp_first   = 1'b1;
        after_abort = 1'b1;
    endtask

    task automatic run_all();
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_rs    = 1'b0;
        req_nib   = 4'h0;
        repeat (4) @(negedge clk);
        chk(!ser_clk && !ser_dat, "R1", "lines in reset", int'({ser_clk, ser_dat}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(!ser_clk && !ser_dat, "R1", "lines after reset", int'({ser_clk, ser_dat}), 0);
        exp_first = 1'b1;
        repeat (5) @(negedge clk);
        chk(!ser_clk && !ser_dat, "R1", "lines while idle", int'({ser_clk, ser_dat}), 0);
        do_write(1'b0, 4'h0);
        do_write(1'b1, 4'hF);
        do_write(1'b1, 4'hA);
        do_write(1'b0, 4'h5);
        for (int k = 0; k < 20; k++) do_write(1'($urandom % 2), 4'($urandom % 16));
        abort_write();
        do_write(1'b1, 4'h3);
        do_write(1'b0, 4'hC);
        for (int k = 0; k < 6; k++) do_write(1'($urandom % 2), 4'($urandom % 16));
    endtask

    initial begin
        void'($urandom(32'd4177));
        timed_out   = 1'b0;
        after_abort = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule